// File: doc/BRIEF.md
# Sliding-Window Serial Palindrome Detector

This block watches a continuous serial stream that delivers one bit on every clock. It keeps the most recent `WIN_LEN` bits in a shift window that moves forward by one position per cycle. Each cycle it tests whether that window is mirror-symmetric, meaning it reads the same from either end. There are no start or stop markers. Every overlapping window is tested in turn, so a match can begin at any bit offset.

The symmetry test is a fixed set of pairwise bit comparisons selected at elaboration time. It uses no state machine. The result is registered and appears on `match_o` as a pulse. After reset, the output stays low until the window has been completely refilled with real stream bits. The window length is a parameter: the default is 12, and the same code builds a 32-bit window.

Top module: `pal_detector`

## Requirements
- R1: While `rst` is high at a rising edge, `match_o` is low after that edge. This holds even if the stream was matching just before reset.
- R2: Every rising edge with `rst` low shifts `bit_i` into the window as its newest bit. The oldest bit drops out, and no bit is skipped or repeated.
- R3: Suppose the window is full and mirror-symmetric after the edge that samples a bit. Then `match_o` is high after the following edge, exactly one cycle later.
- R4: When the window is not mirror-symmetric, `match_o` is low in the cycle that corresponds to that window.
- R5: After reset, `match_o` stays low until `WIN_LEN` bits have been sampled. This holds even though the cleared all-zero contents are symmetric. For the default length of 12, the first possible pulse follows the 13th sampled bit.
- R6: When the window is symmetric on consecutive cycles, `match_o` is high on every one of those cycles. An all-ones stream therefore keeps it high continuously.
- R7: A symmetric window is detected at any bit offset of the stream. No framing or alignment is involved.
- R8: For an odd `WIN_LEN`, the middle bit is not compared. For length 5, both `10001` and `10101` match.
- R9: A reset in the middle of the stream restarts the fill suppression of R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; clears the window, the fill count and the output |
| bit_i | input | 1 | Serial stream bit, sampled on every rising edge |
| match_o | output | 1 | Registered pulse, high while the previous window was full and symmetric |

## Verification
A bit driven before rising edge k becomes part of the window at edge k. Its verdict is registered at edge k+1. The bench therefore predicts each cycle's expected `match_o` from its own copy of the window taken before the current edge. It samples the output at the falling edge after the next rising edge. The fill-suppression checks count sampled bits from the end of reset and expect the first possible pulse on the cycle after bit number `WIN_LEN`. A second instance with an odd length runs alongside the first, so the ignored middle bit is tested at a cycle-exact position.

// File: rtl/pal_pkg.sv
package pal_pkg;

  // Width of a counter able to hold the values 0..n inclusive.
  function automatic int unsigned fill_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Number of mirrored bit pairs compared for a window of n bits.
  function automatic int unsigned pair_count(input int unsigned n);
    return n / 2;
  endfunction

endpackage

// File: rtl/pal_shift_window.sv
module pal_shift_window #(
  parameter int unsigned WIN_LEN = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_i,
  output logic [WIN_LEN-1:0] win_o
);

  // Bit 0 holds the newest sample, bit WIN_LEN-1 the oldest.
  logic [WIN_LEN-1:0] win_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '0;
    end else begin
      win_q <= {win_q[WIN_LEN-2:0], bit_i};
    end
  end

  assign win_o = win_q;

endmodule

// File: rtl/pal_fill_count.sv
module pal_fill_count #(
  parameter int unsigned WIN_LEN = 12,
  parameter int unsigned CNT_W   = pal_pkg::fill_width(WIN_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);

  localparam logic [CNT_W-1:0] FULL_VAL = CNT_W'(WIN_LEN);

  logic [CNT_W-1:0] cnt_q;

  // Saturating count of bits sampled since reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_q != FULL_VAL) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == FULL_VAL);

endmodule

// File: rtl/pal_mirror_cmp.sv
module pal_mirror_cmp #(
  parameter int unsigned WIN_LEN = 12
) (
  input  logic [WIN_LEN-1:0] win_i,
  output logic               sym_o
);

  localparam int unsigned PAIRS = pal_pkg::pair_count(WIN_LEN);

  logic [PAIRS-1:0] pair_eq;

  // One equality per mirrored pair; an odd middle bit has no partner.
  for (genvar gi = 0; gi < PAIRS; gi++) begin : g_pair
    assign pair_eq[gi] = (win_i[gi] == win_i[WIN_LEN-1-gi]);
  end

  assign sym_o = &pair_eq;

endmodule

// File: rtl/pal_detector.sv
module pal_detector #(
  parameter int unsigned WIN_LEN = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_i,
  output logic match_o
);

  localparam int unsigned CNT_W = pal_pkg::fill_width(WIN_LEN);

  logic [WIN_LEN-1:0] win_q;
  logic [CNT_W-1:0]   fill_q;
  logic               full;
  logic               sym;
  logic               match_q;

  pal_shift_window #(.WIN_LEN(WIN_LEN)) u_window (
    .clk   (clk),
    .rst   (rst),
    .bit_i (bit_i),
    .win_o (win_q)
  );

  pal_fill_count #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_fill (
    .clk    (clk),
    .rst    (rst),
    .cnt_o  (fill_q),
    .full_o (full)
  );

  pal_mirror_cmp #(.WIN_LEN(WIN_LEN)) u_cmp (
    .win_i (win_q),
    .sym_o (sym)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= 1'b0;
    end else begin
      match_q <= full & sym;
    end
  end

  assign match_o = match_q;

endmodule

// File: rtl/pal_detector_chk.sv
module pal_detector_chk #(
  parameter int unsigned WIN_LEN = 12,
  parameter int unsigned CNT_W   = pal_pkg::fill_width(WIN_LEN)
) (
  input logic               clk,
  input logic               rst,
  input logic               bit_i,
  input logic               match_o,
  input logic [WIN_LEN-1:0] win,
  input logic [CNT_W-1:0]   fill
);

  localparam logic [CNT_W-1:0] FULL_VAL = CNT_W'(WIN_LEN);

  logic mirrored;
  always_comb begin
    mirrored = 1'b1;
    for (int i = 0; i < WIN_LEN / 2; i++) begin
      if (win[i] != win[WIN_LEN-1-i]) mirrored = 1'b0;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !match_o); // R1
  AST_NEWEST_BIT: assert property (@(posedge clk) disable iff (rst)
    !rst |=> win[0] == $past(bit_i)); // R2
  AST_WINDOW_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    !rst |=> win[WIN_LEN-1:1] == $past(win[WIN_LEN-2:0])); // R2
  AST_MATCH_PULSE: assert property (@(posedge clk) disable iff (rst)
    (fill == FULL_VAL && mirrored) |=> match_o); // R3
  AST_NO_FALSE_MATCH: assert property (@(posedge clk) disable iff (rst)
    !mirrored |=> !match_o); // R4
  AST_FILL_SUPPRESS: assert property (@(posedge clk) disable iff (rst)
    (fill != FULL_VAL) |=> !match_o); // R5
  AST_FILL_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (fill == FULL_VAL) |=> fill == FULL_VAL); // R5

endmodule

bind pal_detector pal_detector_chk #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .bit_i   (bit_i),
  .match_o (match_o),
  .win     (win_q),
  .fill    (fill_q)
);

// File: tb/pal_detector_tb_top.sv
module pal_detector_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic din = 1'b0;
  logic p12, p5;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] h12, h5;
  int c12, c5;

  pal_detector #(.WIN_LEN(12)) dut_i (
    .clk(clk), .rst(rst), .bit_i(din), .match_o(p12));

  pal_detector #(.WIN_LEN(5)) dut_odd_i (
    .clk(clk), .rst(rst), .bit_i(din), .match_o(p5));

  function automatic bit is_pal(input logic [31:0] h, input int n);
    for (int i = 0; i < n / 2; i++) if (h[i] !== h[n-1-i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Drive one bit, let it be sampled, compare both outputs to the model.
  task automatic push(input logic b, input string req, output logic got12, output logic got5);
    logic e12, e5;
    e12 = (c12 >= 12) && is_pal(h12, 12);
    e5  = (c5 >= 5) && is_pal(h5, 5);
    din = b;
    @(posedge clk);
    h12 = {h12[30:0], b};
    h5  = {h5[30:0], b};
    if (c12 < 12) c12++;
    if (c5 < 5) c5++;
    @(negedge clk);
    chk(req, "match(12)", p12, e12);
    chk("R8", "match(5)", p5, e5);
    got12 = p12;
    got5  = p5;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    din = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", "match(12) in reset", p12, 1'b0);
    chk("R1", "match(5) in reset", p5, 1'b0);
    rst = 1'b0;
    h12 = '0; h5 = '0; c12 = 0; c5 = 0;
  endtask

  task automatic t_zero_fill();
    logic g12, g5;
    int first;
    do_reset();
    first = 0;
    for (int i = 1; i <= 20; i++) begin
      push(1'b0, "R5", g12, g5);
      if (g12 && first == 0) first = i;
    end
    chk_int("R5", "first pulse index after reset", first, 13);
  endtask

  task automatic t_embedded();
    logic g12, g5;
    logic [6:0]  prefix = 7'b1001110;
    logic [11:0] pal = 12'b110100001011;
    do_reset();
    for (int i = 6; i >= 0; i--) push(prefix[i], "R7", g12, g5);
    for (int i = 11; i >= 0; i--) push(pal[i], "R7", g12, g5);
    push(1'b0, "R3", g12, g5);
    chk("R3", "pulse one cycle after offset palindrome", g12, 1'b1);
  endtask

  task automatic t_ones();
    logic g12, g5;
    int highs;
    do_reset();
    highs = 0;
    for (int i = 1; i <= 30; i++) begin
      push(1'b1, "R6", g12, g5);
      if (g12) highs++;
    end
    chk_int("R6", "consecutive highs for all-ones stream", highs, 18);
  endtask

  task automatic t_alternating();
    logic g12, g5;
    int highs;
    do_reset();
    highs = 0;
    for (int i = 0; i < 40; i++) begin
      push(i[0], "R4", g12, g5);
      if (g12) highs++;
    end
    chk_int("R4", "highs for alternating stream", highs, 0);
  endtask

  task automatic t_lfsr();
    logic g12, g5;
    logic [15:0] lfsr = 16'hACE1;
    do_reset();
    for (int i = 0; i < 400; i++) begin
      push(lfsr[0], "R2", g12, g5);
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    end
  endtask

  task automatic t_odd();
    logic g12, g5;
    logic [4:0] a = 5'b10001;
    logic [4:0] b = 5'b10101;
    do_reset();
    for (int i = 4; i >= 0; i--) push(a[i], "R8", g12, g5);
    push(1'b1, "R8", g12, g5);
    chk("R8", "odd window 10001 matches", g5, 1'b1);
    for (int i = 3; i >= 0; i--) push(b[i], "R8", g12, g5);
    push(1'b0, "R8", g12, g5);
    chk("R8", "odd window 10101 matches", g5, 1'b1);
  endtask

  task automatic t_midreset();
    logic g12, g5;
    int highs;
    do_reset();
    for (int i = 0; i < 20; i++) push(1'b1, "R6", g12, g5);
    chk("R9", "stream matching before reset", g12, 1'b1);
    do_reset();
    highs = 0;
    for (int i = 0; i < 12; i++) begin
      push(1'b1, "R9", g12, g5);
      if (g12) highs++;
    end
    chk_int("R9", "highs during refill after mid-stream reset", highs, 0);
    push(1'b1, "R9", g12, g5);
    chk("R9", "pulse on 13th bit after reset", g12, 1'b1);
  endtask

  initial begin
    h12 = '0; h5 = '0; c12 = 0; c5 = 0;
    @(negedge clk);
    t_zero_fill();
    t_embedded();
    t_ones();
    t_alternating();
    t_lfsr();
    t_odd();
    t_midreset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule